// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from three kinds of source and hands the CPU one request at a time. The first kind is an encoded external level: a 4-bit input whose non-zero value is both the request and its priority. The second is a set of IRQ lines, each with a programmable priority. The third is a group of on-chip peripheral modules. Each module owns one programmable priority field, and all the sources inside a module share that field. Every source has its own vector number, so the service routine never has to find out which source fired.

In each arbitration cycle the block looks at every pending request whose priority is strictly above the CPU's current 4-bit mask. It selects the one with the highest priority. Ties are settled by a fixed order that software cannot change. The winner is held on a registered valid/level/vector output until the CPU acknowledges it. The CPU then loads its mask with the reported level. IRQ lines can be configured as edge-latched, in which case the acknowledge clears the latch. Peripheral and external requests are level requests: the source itself keeps them asserted until it is serviced. Priority fields live in 16-bit words, four fields per word. These words are written and read through a small address/write-enable/data port.

Top module: `prio_intc`

## Requirements
- R1: While reset is asserted and right after it, `irq_valid` is 0 and every priority word reads 0.
- R2: Word `a` holds field `4a+k` in bits `[4k+3:4k]`. Fields 0 to NUM_IRQ-1 belong to IRQ lines 0 upward. The next NUM_MOD fields belong to peripheral modules 0 upward. Bit positions with no field behind them always read 0 and ignore writes.
- R3: A request is accepted only if its priority is strictly greater than `cpu_mask`. A source whose priority is 0 is never accepted.
- R4: Among acceptable requests, the highest priority wins. On equal priority the fixed order decides: the external level first, then IRQ lines by rising index, then peripheral sources module by module, lower source index first within a module.
- R5: An external level value L from 1 to 15 is a request with priority L and vector EXT_VEC_BASE+L. The value 0 means no request.
- R6: IRQ line i has vector IRQ_VEC_BASE+i. Source s of peripheral module m has vector PER_VEC_BASE+m·SRC_PER_MOD+s. That source is bit m·SRC_PER_MOD+s of `per_req`.
- R7: The output is registered. A request visible to the arbiter at one clock edge appears on `irq_valid`/`irq_level`/`irq_vector` after that edge. While `irq_valid` is 1 and no acknowledge is given, all three hold their values, whatever the requests and the mask do.
- R8: An `irq_ack` sampled while `irq_valid` is 1 clears `irq_valid` at that edge. The next winner appears one edge later at the earliest. An `irq_ack` while `irq_valid` is 0 has no effect.
- R9: With edge latching, a rising edge on an IRQ line becomes pending one edge later. It stays pending after the line falls, and only an acknowledge of that line's vector clears it. Peripheral and external requests are not latched: a level request that is still present after its acknowledge is presented again.
- R10: A priority word written at one edge is used by the arbitration at the following edge, not at the edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_level | input | 4 | Encoded external request level, 0 = none |
| irq_in | input | NUM_IRQ | IRQ request lines |
| per_req | input | NUM_MOD·SRC_PER_MOD | Peripheral source request levels |
| cpu_mask | input | 4 | Current CPU interrupt mask level |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| reg_addr | input | clog2(words) | Priority word address |
| reg_we | input | 1 | Priority word write enable |
| reg_wdata | input | 16 | Priority word write data |
| reg_rdata | output | 16 | Priority word read data (combinational) |
| irq_valid | output | 1 | A request is being presented |
| irq_level | output | 4 | Priority of the presented request |
| irq_vector | output | 8 | Vector number of the presented request |

## Verification
The bench targets the boundary where priority equals the mask. A design that compares with greater-or-equal would take an interrupt that the CPU has already masked. It also drives equal-priority races between the external level and an IRQ line, between two modules, and between two sources of one module. A reversed or unstable tie order would show up as a wrong vector. The bench checks that a one-cycle IRQ pulse survives until it is acknowledged and then disappears, while a held peripheral request comes back after a single idle cycle. A design that let the acknowledge clear the wrong latch would lose or repeat interrupts. Writes to unimplemented field bits, and a priority write racing with a pending request, expose a register that stores dead bits or an arbiter that sees a write in the same cycle.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

   localparam int PRI_W       = 4;
   localparam int VEC_W       = 8;
   localparam int REG_W       = 16;
   localparam int FLD_PER_REG = REG_W / PRI_W;

   typedef logic [PRI_W-1:0] pri_t;
   typedef logic [VEC_W-1:0] vec_t;

   // one arbitration candidate
   typedef struct packed {
      logic req;
      pri_t pri;
      vec_t vec;
   } cand_t;

endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
   import prio_intc_pkg::*;
#(
   parameter int NUM_FIELD = 13,
   parameter int ADDR_W    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       we,
   input  logic [REG_W-1:0]           wdata,
   output logic [REG_W-1:0]           rdata,
   output logic [NUM_FIELD-1:0][PRI_W-1:0] fld
);

   localparam int NUM_WORDS = 2 ** ADDR_W;

   logic [REG_W-1:0] bank [NUM_WORDS];

   for (genvar r = 0; r < NUM_WORDS; r++) begin : g_word
      localparam int NF_RAW = NUM_FIELD - r * FLD_PER_REG;
      localparam int NF     = (NF_RAW < 0) ? 0 :
                              ((NF_RAW > FLD_PER_REG) ? FLD_PER_REG : NF_RAW);
      localparam logic [REG_W-1:0] IMASK = REG_W'((64'd1 << (PRI_W * NF)) - 64'd1);

      logic [REG_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (we && (addr == ADDR_W'(r))) begin
            word_q <= wdata & IMASK;
         end
      end

      assign bank[r] = word_q;
   end

   assign rdata = bank[addr];

   for (genvar f = 0; f < NUM_FIELD; f++) begin : g_fld
      assign fld[f] = bank[f / FLD_PER_REG][(f % FLD_PER_REG) * PRI_W +: PRI_W];
   end

endmodule

// File: rtl/prio_intc_src.sv
module prio_intc_src #(
   parameter int NUM_IRQ = 4,
   parameter bit EDGE    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] line,
   input  logic [NUM_IRQ-1:0] clr,
   output logic [NUM_IRQ-1:0] pend
);

   if (EDGE) begin : g_edge
      logic [NUM_IRQ-1:0] prev_q;
      logic [NUM_IRQ-1:0] pend_q;

      // a new edge wins over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
         end else begin
            prev_q <= line;
            pend_q <= (pend_q & ~clr) | (line & ~prev_q);
         end
      end

      assign pend = pend_q;
   end else begin : g_level
      logic [NUM_IRQ-1:0] samp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            samp_q <= '0;
         end else begin
            samp_q <= line & ~clr;
         end
      end

      assign pend = samp_q;
   end

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
   import prio_intc_pkg::*;
#(
   parameter int NUM_CAND = 23,
   parameter int IDX_W    = 5
) (
   input  cand_t [NUM_CAND-1:0] cand,
   input  pri_t                 mask,
   output logic                 hit,
   output pri_t                 win_pri,
   output vec_t                 win_vec,
   output logic [IDX_W-1:0]     win_idx
);

   // ascending scan with strict compare: the first index at the
   // highest level wins, and only levels above the mask are taken
   always_comb begin
      hit     = 1'b0;
      win_pri = mask;
      win_vec = '0;
      win_idx = '0;
      for (int i = 0; i < NUM_CAND; i++) begin
         if (cand[i].req && (cand[i].pri > win_pri)) begin
            hit     = 1'b1;
            win_pri = cand[i].pri;
            win_vec = cand[i].vec;
            win_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int NUM_IRQ      = 4,
   parameter int NUM_MOD      = 9,
   parameter int SRC_PER_MOD  = 2,
   parameter int EXT_VEC_BASE = 64,
   parameter int IRQ_VEC_BASE = 80,
   parameter int PER_VEC_BASE = 96,
   parameter bit IRQ_EDGE     = 1'b1
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic [3:0]                                 ext_level,
   input  logic [NUM_IRQ-1:0]                         irq_in,
   input  logic [NUM_MOD*SRC_PER_MOD-1:0]             per_req,
   input  logic [3:0]                                 cpu_mask,
   input  logic                                       irq_ack,
   input  logic [$clog2((NUM_IRQ+NUM_MOD+3)/4)-1:0]   reg_addr,
   input  logic                                       reg_we,
   input  logic [15:0]                                reg_wdata,
   output logic [15:0]                                reg_rdata,
   output logic                                       irq_valid,
   output logic [3:0]                                 irq_level,
   output logic [7:0]                                 irq_vector
);

   localparam int NUM_FIELD = NUM_IRQ + NUM_MOD;
   localparam int NUM_REG   = (NUM_FIELD + FLD_PER_REG - 1) / FLD_PER_REG;
   localparam int ADDR_W    = $clog2(NUM_REG);
   localparam int NUM_PER   = NUM_MOD * SRC_PER_MOD;
   localparam int NUM_CAND  = 1 + NUM_IRQ + NUM_PER;
   localparam int IDX_W     = $clog2(NUM_CAND);
   localparam int IRQ_FIRST = 1;

   // elaboration-time parameter checks
   if (NUM_IRQ < 1 || NUM_MOD < 1 || SRC_PER_MOD < 1) begin : g_bad_count
      $error("prio_intc: source counts must be at least 1");
   end
   if (NUM_FIELD <= FLD_PER_REG) begin : g_bad_words
      $error("prio_intc: at least two priority words are required");
   end
   if (EXT_VEC_BASE < 0 || EXT_VEC_BASE + 16 > IRQ_VEC_BASE) begin : g_bad_ext
      $error("prio_intc: external vector range overlaps IRQ range");
   end
   if (IRQ_VEC_BASE + NUM_IRQ > PER_VEC_BASE) begin : g_bad_irq
      $error("prio_intc: IRQ vector range overlaps peripheral range");
   end
   if (PER_VEC_BASE + NUM_PER > 2 ** VEC_W) begin : g_bad_per
      $error("prio_intc: peripheral vectors exceed vector width");
   end

   logic [NUM_FIELD-1:0][PRI_W-1:0] fld;
   logic [NUM_IRQ-1:0]              irq_pend;
   logic [NUM_IRQ-1:0]              irq_clr;
   cand_t [NUM_CAND-1:0]            cand;
   logic                            win_hit;
   pri_t                            win_pri;
   vec_t                            win_vec;
   logic [IDX_W-1:0]                win_idx;
   logic [IDX_W-1:0]                src_q;

   prio_intc_regs #(
      .NUM_FIELD (NUM_FIELD),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (reg_addr),
      .we    (reg_we),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .fld   (fld)
   );

   prio_intc_src #(
      .NUM_IRQ (NUM_IRQ),
      .EDGE    (IRQ_EDGE)
   ) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .line  (irq_in),
      .clr   (irq_clr),
      .pend  (irq_pend)
   );

   // candidate 0: encoded external level, priority is the level itself
   assign cand[0].req = |ext_level;
   assign cand[0].pri = ext_level;
   assign cand[0].vec = VEC_W'(EXT_VEC_BASE) + VEC_W'(ext_level);

   // candidates 1..NUM_IRQ: IRQ lines with their own fields
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      assign cand[IRQ_FIRST+i].req = irq_pend[i];
      assign cand[IRQ_FIRST+i].pri = fld[i];
      assign cand[IRQ_FIRST+i].vec = VEC_W'(IRQ_VEC_BASE + i);
      assign irq_clr[i] = irq_valid && irq_ack && (src_q == IDX_W'(IRQ_FIRST + i));
   end

   // remaining candidates: peripheral sources, module-major order,
   // each module's sources share one field
   for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      for (genvar s = 0; s < SRC_PER_MOD; s++) begin : g_srcs
         localparam int Q = m * SRC_PER_MOD + s;
         assign cand[1+NUM_IRQ+Q].req = per_req[Q];
         assign cand[1+NUM_IRQ+Q].pri = fld[NUM_IRQ+m];
         assign cand[1+NUM_IRQ+Q].vec = VEC_W'(PER_VEC_BASE + Q);
      end
   end

   prio_intc_arb #(
      .NUM_CAND (NUM_CAND),
      .IDX_W    (IDX_W)
   ) u_arb (
      .cand    (cand),
      .mask    (cpu_mask),
      .hit     (win_hit),
      .win_pri (win_pri),
      .win_vec (win_vec),
      .win_idx (win_idx)
   );

   // presentation register: load on a win while idle, hold until acknowledged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_level  <= '0;
         irq_vector <= '0;
         src_q      <= '0;
      end else if (irq_valid) begin
         if (irq_ack) begin
            irq_valid <= 1'b0;
         end
      end else if (win_hit) begin
         irq_valid  <= 1'b1;
         irq_level  <= win_pri;
         irq_vector <= win_vec;
         src_q      <= win_idx;
      end
   end

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
   parameter int EXT_VEC_BASE = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] cpu_mask,
   input logic       irq_ack,
   input logic       irq_valid,
   input logic [3:0] irq_level,
   input logic [7:0] irq_vector
);

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> !irq_valid);

   assert_above_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_valid) |-> (irq_level > $past(cpu_mask)));

   assert_level_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_level != 4'd0));

   assert_ext_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && (int'(irq_vector) > EXT_VEC_BASE) && (int'(irq_vector) <= EXT_VEC_BASE + 15))
      |-> (int'(irq_level) == int'(irq_vector) - EXT_VEC_BASE));

   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_level) && $stable(irq_vector)));

   assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_ack) |=> !irq_valid);

endmodule

bind prio_intc prio_intc_chk #(.EXT_VEC_BASE(EXT_VEC_BASE)) u_chk (.*);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;

   localparam int NUM_IRQ   = 4;
   localparam int NUM_MOD   = 9;
   localparam int SPM       = 2;
   localparam int EXT_BASE  = 64;
   localparam int IRQ_BASE  = 80;
   localparam int PER_BASE  = 96;
   localparam int NUM_PER   = NUM_MOD * SPM;
   localparam int NUM_FIELD = NUM_IRQ + NUM_MOD;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [3:0]         ext_level = '0;
   logic [NUM_IRQ-1:0] irq_in = '0;
   logic [NUM_PER-1:0] per_req = '0;
   logic [3:0]         cpu_mask = '0;
   logic               irq_ack = 1'b0;
   logic [1:0]         reg_addr = '0;
   logic               reg_we = 1'b0;
   logic [15:0]        reg_wdata = '0;
   logic [15:0]        reg_rdata;
   logic               irq_valid;
   logic [3:0]         irq_level;
   logic [7:0]         irq_vector;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   prio_intc dut_i (
      .clk(clk), .rst_n(rst_n), .ext_level(ext_level), .irq_in(irq_in),
      .per_req(per_req), .cpu_mask(cpu_mask), .irq_ack(irq_ack),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_level(irq_level),
      .irq_vector(irq_vector)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int  m_reg [4];
   bit  m_pend [NUM_IRQ];
   bit  m_prev [NUM_IRQ];
   bit  m_valid;
   int  m_lvl, m_vec, m_src;

   function automatic int imask(int a);
      int n = NUM_FIELD - 4 * a;
      if (n < 0) n = 0;
      if (n > 4) n = 4;
      return (1 << (4 * n)) - 1;
   endfunction

   function automatic int fv(int f);
      return (m_reg[f / 4] >> (4 * (f % 4))) & 15;
   endfunction

   always @(posedge clk) begin : mdl
      int best, widx, wvec;
      if (!rst_n) begin
         foreach (m_reg[a]) m_reg[a] = 0;
         for (int i = 0; i < NUM_IRQ; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
         m_valid = 0; m_lvl = 0; m_vec = 0; m_src = -1;
      end else begin
         best = int'(cpu_mask); widx = -1; wvec = 0;
         if (!m_valid) begin
            if (int'(ext_level) > best) begin
               best = int'(ext_level); widx = 0; wvec = EXT_BASE + int'(ext_level);
            end
            for (int i = 0; i < NUM_IRQ; i++)
               if (m_pend[i] && fv(i) > best) begin
                  best = fv(i); widx = 1 + i; wvec = IRQ_BASE + i;
               end
            for (int q = 0; q < NUM_PER; q++)
               if (per_req[q] && fv(NUM_IRQ + q / SPM) > best) begin
                  best = fv(NUM_IRQ + q / SPM); widx = 1 + NUM_IRQ + q; wvec = PER_BASE + q;
               end
         end
         if (m_valid && irq_ack && m_src >= 1 && m_src <= NUM_IRQ) m_pend[m_src-1] = 0;
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (irq_in[i] && !m_prev[i]) m_pend[i] = 1;
            m_prev[i] = irq_in[i];
         end
         if (m_valid) begin
            if (irq_ack) m_valid = 0;
         end else if (widx >= 0) begin
            m_valid = 1; m_lvl = best; m_vec = wvec; m_src = widx;
         end
         if (reg_we) m_reg[reg_addr] = int'(reg_wdata) & imask(int'(reg_addr));
      end
      #1;
      if (rst_n && !done) begin
         chk(irq_valid == m_valid, "R7 model irq_valid", int'(irq_valid), int'(m_valid));
         if (m_valid) begin
            chk(int'(irq_level) == m_lvl, "R4 model irq_level", int'(irq_level), m_lvl);
            chk(int'(irq_vector) == m_vec, "R6 model irq_vector", int'(irq_vector), m_vec);
         end
         chk(int'(reg_rdata) == m_reg[reg_addr], "R2 model reg_rdata", int'(reg_rdata), m_reg[reg_addr]);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      reg_addr = 2'(a); reg_wdata = 16'(d); reg_we = 1'b1;
      cyc(1);
      reg_we = 1'b0;
   endtask

   task automatic ack_it();
      irq_ack = 1'b1;
      cyc(1);
      irq_ack = 1'b0;
   endtask

   task automatic expect_irq(input string tag, input int lvl, input int vec);
      chk(irq_valid == 1'b1, {tag, " valid"}, int'(irq_valid), 1);
      chk(int'(irq_level) == lvl, {tag, " level"}, int'(irq_level), lvl);
      chk(int'(irq_vector) == vec, {tag, " vector"}, int'(irq_vector), vec);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
      end
   end

   // ---------------- directed and random stimulus ----------------
   initial begin
      cyc(2);
      chk(irq_valid == 1'b0, "R1 valid in reset", int'(irq_valid), 0);
      for (int a = 0; a < 4; a++) begin
         reg_addr = 2'(a);
         #0.5;
         chk(reg_rdata == 16'h0, "R1 word zero in reset", int'(reg_rdata), 0);
      end
      reg_addr = '0;
      cyc(1);
      rst_n = 1'b1;
      cyc(2);
      chk(irq_valid == 1'b0, "R1 valid after reset", int'(irq_valid), 0);

      // R2: register layout and unimplemented bits
      wr(0, 16'h4321);
      reg_addr = 2'd0; #0.5;
      chk(reg_rdata == 16'h4321, "R2 word0 readback", int'(reg_rdata), 16'h4321);
      wr(3, 16'hFFFF);
      reg_addr = 2'd3; #0.5;
      chk(reg_rdata == 16'h000F, "R2 word3 only field 12 stored", int'(reg_rdata), 16'h000F);
      wr(3, 16'h0000);
      wr(0, 16'h0000);

      // R6/R7: module 0 source 1 at priority 5 over mask 3
      wr(1, 16'h0005);
      cpu_mask = 4'd3; per_req = 18'h2;
      cyc(1);
      expect_irq("R7 R6 module0 src1", 5, PER_BASE + 1);
      cpu_mask = 4'd9; per_req = 18'h3FFFF; ext_level = 4'd15;
      cyc(3);
      expect_irq("R7 held while unacknowledged", 5, PER_BASE + 1);
      per_req = 18'h2; ext_level = 4'd0; cpu_mask = 4'd0;
      ack_it();
      chk(irq_valid == 1'b0, "R8 valid drops on ack", int'(irq_valid), 0);
      cyc(1);
      expect_irq("R9 held level request re-presented", 5, PER_BASE + 1);
      per_req = '0;
      ack_it();
      irq_ack = 1'b1;
      cyc(2);
      irq_ack = 1'b0;
      chk(irq_valid == 1'b0, "R8 ack while idle has no effect", int'(irq_valid), 0);

      // R3: equal to mask is rejected, priority 0 is never taken
      cpu_mask = 4'd5; per_req = 18'h2;
      cyc(3);
      chk(irq_valid == 1'b0, "R3 priority equal to mask", int'(irq_valid), 0);
      cpu_mask = 4'd0; per_req = 18'h4;
      cyc(3);
      chk(irq_valid == 1'b0, "R3 priority zero disabled", int'(irq_valid), 0);
      per_req = '0;

      // R4: ties and priority order
      wr(1, 16'h0077);
      per_req = 18'h6;
      cyc(1);
      expect_irq("R4 tie across modules lower module", 7, PER_BASE + 1);
      per_req = '0; ack_it();
      per_req = 18'h3;
      cyc(1);
      expect_irq("R4 tie within module lower source", 7, PER_BASE + 0);
      per_req = '0; ack_it();
      wr(1, 16'h0073);
      per_req = 18'h5;
      cyc(1);
      expect_irq("R4 higher priority beats lower index", 7, PER_BASE + 2);
      per_req = '0; ack_it();
      cyc(1);

      // R5: external level
      ext_level = 4'd9;
      cyc(1);
      expect_irq("R5 external level 9", 9, EXT_BASE + 9);
      ext_level = 4'd0; ack_it();
      cyc(1);

      // R4/R9: external vs IRQ tie, then latched IRQ survives
      wr(0, 16'h0007);
      irq_in = 4'b0001;
      cyc(1);
      irq_in = 4'b0000; ext_level = 4'd7;
      cyc(1);
      expect_irq("R4 external wins tie with IRQ", 7, EXT_BASE + 7);
      ext_level = 4'd0;
      ack_it();
      chk(irq_valid == 1'b0, "R8 gap after ack", int'(irq_valid), 0);
      cyc(1);
      expect_irq("R9 latched IRQ0 after line fell", 7, IRQ_BASE + 0);
      ack_it();
      cyc(2);
      chk(irq_valid == 1'b0, "R9 latch cleared by ack", int'(irq_valid), 0);

      // R10: write visible one edge later
      wr(0, 16'h0000);
      irq_in = 4'b0001;
      cyc(1);
      irq_in = 4'b0000;
      cyc(2);
      chk(irq_valid == 1'b0, "R10 pending IRQ with priority 0", int'(irq_valid), 0);
      wr(0, 16'h0004);
      chk(irq_valid == 1'b0, "R10 not used at write edge", int'(irq_valid), 0);
      cyc(1);
      expect_irq("R10 used at following edge", 4, IRQ_BASE + 0);
      ack_it();
      cyc(1);

      // random traffic compared against the model every clock
      for (int n = 0; n < 4000; n++) begin
         per_req   = 18'($urandom) & 18'($urandom) & 18'($urandom);
         irq_in    = 4'($urandom);
         ext_level = ($urandom % 6 == 0) ? 4'($urandom) : 4'd0;
         cpu_mask  = 4'($urandom % 12);
         irq_ack   = (irq_valid && ($urandom % 3 == 0)) || ($urandom % 9 == 0);
         reg_we    = ($urandom % 8 == 0);
         reg_addr  = 2'($urandom);
         reg_wdata = 16'($urandom);
         cyc(1);
      end
      irq_ack = 1'b0; reg_we = 1'b0;
      cyc(2);
      summary();
   end

endmodule